// File: doc/BRIEF.md
# Peripheral Event-to-Task Routing Matrix

This block is a crossbar that software programs over a simple register bus. It links single-cycle event pulses raised by peripherals to single-cycle task pulses that trigger other peripherals. It has a fixed number of channels. Each channel stores one event selector and one task selector. When a channel is enabled and its selected event input pulses, the selected task output pulses one clock later.

Channel enables are never written directly. Software turns channels on through set words and off through clear words. The enables sit in two 32-bit banks, and each bank also has a read-only status word. Several channels may listen to the same event and drive the same task. Their results are ORed, so each task output carries at most one pulse per cycle.

Top module: `evt_task_matrix`

## Requirements
- R1: After reset, every channel is disabled, every event and task selector reads 0, and `task_o` is all zero.
- R2: Word address 0 returns the enables of channels 0..31, with channel c at bit c. Word address 3 returns the enables of channels 32..49, with channel c at bit c-32. A channel's enable does not change unless a set or clear word is written.
- R3: Writing word 1 (bank 0) or word 4 (bank 1) enables every channel whose bit is 1. A 0 bit leaves that channel as it was.
- R4: Writing word 2 (bank 0) or word 5 (bank 1) disables every channel whose bit is 1. A 0 bit leaves that channel as it was. The set and clear words always read 0.
- R5: For channel c, word 6+2c holds the 8-bit event selector and word 7+2c holds the 8-bit task selector. Both are written from `bus_wdata[7:0]` and read back zero-extended.
- R6: Suppose an enabled channel has event selector e and task selector t, and `evt_i[e]` is high in cycle n. Then `task_o[t]` is high in cycle n+1 and lasts one cycle per event cycle.
- R7: A disabled channel produces no task pulse.
- R8: An event selector of 0 never fires, whatever the state of `evt_i`.
- R9: An event selector of 64 or more, or a task selector of 64 or more, produces no pulse on any task output.
- R10: A task output is the OR of all enabled channels that target it. Channels that share an event or a task act independently.
- R11: Bank-1 bits 18..31 read as 0 and ignore writes. Writes to the status words (0 and 3) are ignored, and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; clears all enables and selectors |
| evt_i | input | 64 | Event pulses; bit i is event number i (bit 0 is never routed) |
| task_o | output | 64 | Registered task pulses; bit t is task number t |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr`, combinational |

## Verification
The bench concentrates on the split across the bank boundary. If channel 49 were mapped to the wrong bank bit, a pulse would appear on the wrong task. If bank-1 bits above channel 49 were not masked, the status word would read back nonzero. The bench also covers zero bits in set and clear words, which must leave enables alone, and event selector 0 and out-of-range selectors, which must stay silent even with every event input high. A design that took zero bits as clears, fired on event 0, or wrapped large selectors would show a task pulse or a readback that the reference model does not. Shared sources and shared sinks are exercised together, and the timing is checked every cycle, so a pulse that comes a cycle late or stretches over two cycles is reported.

// File: rtl/evt_task_matrix.sv
`timescale 1ns/1ps
module evt_task_matrix #(
  parameter int NUM_CH   = 50,
  parameter int NUM_EVT  = 64,
  parameter int NUM_TASK = 64,
  parameter int ID_W     = 8,
  parameter int AW       = 8,
  parameter int DW       = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_EVT-1:0]  evt_i,
  output logic [NUM_TASK-1:0] task_o,
  input  logic                bus_we,
  input  logic [AW-1:0]       bus_addr,
  input  logic [DW-1:0]       bus_wdata,
  output logic [DW-1:0]       bus_rdata
);
  localparam int B1_W  = NUM_CH - DW;
  localparam int A_ST0 = 0, A_SET0 = 1, A_CLR0 = 2;
  localparam int A_ST1 = 3, A_SET1 = 4, A_CLR1 = 5;
  localparam int A_ID  = 6;

  logic [NUM_CH-1:0]   en;
  logic [ID_W-1:0]     eid [NUM_CH];
  logic [ID_W-1:0]     tid [NUM_CH];
  logic [NUM_CH-1:0]   fire;
  logic [NUM_TASK-1:0] task_d;
  logic [2*DW-1:0]     set_w, clr_w;

  assign set_w = {(bus_we && bus_addr == AW'(A_SET1)) ? bus_wdata : '0,
                  (bus_we && bus_addr == AW'(A_SET0)) ? bus_wdata : '0};
  assign clr_w = {(bus_we && bus_addr == AW'(A_CLR1)) ? bus_wdata : '0,
                  (bus_we && bus_addr == AW'(A_CLR0)) ? bus_wdata : '0};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) en <= '0;
    else        en <= (en | set_w[NUM_CH-1:0]) & ~clr_w[NUM_CH-1:0];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        eid[c] <= '0;
        tid[c] <= '0;
      end else if (bus_we) begin
        if (bus_addr == AW'(A_ID + 2*c))     eid[c] <= bus_wdata[ID_W-1:0];
        if (bus_addr == AW'(A_ID + 2*c + 1)) tid[c] <= bus_wdata[ID_W-1:0];
      end

    always_comb begin
      fire[c] = 1'b0;
      for (int e = 1; e < NUM_EVT; e++)
        if (eid[c] == ID_W'(e) && evt_i[e]) fire[c] = en[c];
    end
  end

  always_comb begin
    task_d = '0;
    for (int t = 0; t < NUM_TASK; t++)
      for (int c = 0; c < NUM_CH; c++)
        if (fire[c] && tid[c] == ID_W'(t)) task_d[t] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) task_o <= '0;
    else        task_o <= task_d;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == AW'(A_ST0)) bus_rdata = en[DW-1:0];
    if (bus_addr == AW'(A_ST1)) bus_rdata = DW'(en[NUM_CH-1:DW]);
    for (int c = 0; c < NUM_CH; c++) begin
      if (bus_addr == AW'(A_ID + 2*c))     bus_rdata = DW'(eid[c]);
      if (bus_addr == AW'(A_ID + 2*c + 1)) bus_rdata = DW'(tid[c]);
    end
  end
endmodule

module evt_task_matrix_chk #(
  parameter int NUM_CH   = 50,
  parameter int NUM_EVT  = 64,
  parameter int NUM_TASK = 64,
  parameter int AW       = 8,
  parameter int DW       = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_EVT-1:0]  evt_i,
  input logic [NUM_TASK-1:0] task_o,
  input logic                bus_we,
  input logic [AW-1:0]       bus_addr,
  input logic [DW-1:0]       bus_wdata,
  input logic [NUM_CH-1:0]   en
);
  localparam int B1_W = NUM_CH - DW;
  logic en_wr;
  assign en_wr = bus_we && (bus_addr == AW'(1) || bus_addr == AW'(2) ||
                            bus_addr == AW'(4) || bus_addr == AW'(5));

  // R3
  set_bank0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == AW'(1)) |=> en[DW-1:0] == ($past(en[DW-1:0]) | $past(bus_wdata)));
  // R4
  clr_bank0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == AW'(2)) |=> en[DW-1:0] == ($past(en[DW-1:0]) & ~$past(bus_wdata)));
  // R11
  set_bank1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == AW'(4)) |=> en[NUM_CH-1:DW] == ($past(en[NUM_CH-1:DW]) | $past(bus_wdata[B1_W-1:0])));
  // R2
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_wr |=> $stable(en));
  // R7
  all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |=> (task_o == '0));
  // R6
  no_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i[NUM_EVT-1:1] == '0) |=> (task_o == '0));
endmodule

bind evt_task_matrix evt_task_matrix_chk #(
  .NUM_CH(NUM_CH), .NUM_EVT(NUM_EVT), .NUM_TASK(NUM_TASK), .AW(AW), .DW(DW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .task_o(task_o), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .en(en)
);

// File: tb/evt_task_matrix_tb.sv
`timescale 1ns/1ps
module evt_task_matrix_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [63:0] evt_i = '0;
  logic [63:0] task_o;
  logic        bus_we = 0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  evt_task_matrix u_dut (.clk(clk), .rst_n(rst_n), .evt_i(evt_i), .task_o(task_o),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  always #2.5 clk = ~clk;

  int total = 0, fails = 0;
  int m_en [50];
  int m_eid [50];
  int m_tid [50];
  logic [63:0] exp_task = '0;
  string prev_req = "R1";

  function automatic logic [31:0] m_read(int a);
    logic [31:0] r = '0;
    if (a == 0) for (int c = 0; c < 32; c++) r[c] = m_en[c][0];
    if (a == 3) for (int c = 32; c < 50; c++) r[c-32] = m_en[c][0];
    if (a >= 6 && a < 106) r = ((a - 6) % 2 == 0) ? m_eid[(a-6)/2] : m_tid[(a-6)/2];
    return r;
  endfunction

  function automatic void m_write(int a, logic [31:0] d);
    for (int c = 0; c < 50; c++) begin
      if (a == 1 && c < 32 && d[c]) m_en[c] = 1;
      if (a == 2 && c < 32 && d[c]) m_en[c] = 0;
      if (a == 4 && c >= 32 && d[c-32]) m_en[c] = 1;
      if (a == 5 && c >= 32 && d[c-32]) m_en[c] = 0;
    end
    if (a >= 6 && a < 106) begin
      if ((a - 6) % 2 == 0) m_eid[(a-6)/2] = int'(d[7:0]);
      else                  m_tid[(a-6)/2] = int'(d[7:0]);
    end
  endfunction

  function automatic logic [63:0] m_route(logic [63:0] ev);
    logic [63:0] r = '0;
    for (int c = 0; c < 50; c++)
      if (m_en[c] != 0 && m_eid[c] != 0 && m_eid[c] < 64 && m_tid[c] < 64)
        if (ev[m_eid[c]]) r[m_tid[c]] = 1'b1;
    return r;
  endfunction

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step(string req, logic [63:0] ev, bit we, int a, logic [31:0] d);
    check(prev_req, "task_o", task_o, exp_task);
    evt_i = ev; bus_we = we; bus_addr = 8'(a); bus_wdata = d;
    #1;
    check(req, "bus_rdata", 64'(bus_rdata), 64'(m_read(a)));
    exp_task = m_route(ev);
    if (we) m_write(a, d);
    prev_req = req;
    @(negedge clk);
  endtask

  task automatic wr(string req, int a, logic [31:0] d); step(req, '0, 1, a, d); endtask
  task automatic rd(string req, int a); step(req, '0, 0, a, '0); endtask
  task automatic ev(string req, logic [63:0] e); step(req, e, 0, 0, '0); endtask

  initial begin
    #(200000 * 5);
    fails++; total++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    for (int c = 0; c < 50; c++) begin m_en[c] = 0; m_eid[c] = 0; m_tid[c] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd("R1", 0); rd("R1", 3); rd("R1", 6); rd("R1", 7); rd("R1", 105);
    ev("R1", '1); ev("R1", '0);
    // R5 selectors
    wr("R5", 6, 5);  wr("R5", 7, 10);
    wr("R5", 104, 63); wr("R5", 105, 63);
    wr("R5", 6 + 66, 5); wr("R5", 7 + 66, 11);
    wr("R5", 8, 32'hFFFF_FF07); wr("R5", 9, 10);
    rd("R5", 6); rd("R5", 105); rd("R5", 8);
    // R7 disabled
    ev("R7", 64'h20); ev("R7", '1); ev("R7", '0);
    // R3 set words, zero bits ignored
    wr("R3", 1, 32'h1); wr("R3", 4, 32'h2_0002); wr("R3", 1, 0); wr("R3", 4, 0);
    rd("R2", 0); rd("R2", 3);
    // R6 routing and timing
    ev("R6", 64'h20); ev("R6", '0); ev("R6", 64'h8000_0000_0000_0000);
    ev("R6", 64'h20); ev("R6", 64'h20); ev("R6", '0); ev("R6", '0);
    // R10 shared sources/sinks
    wr("R10", 1, 32'h2);
    ev("R10", 64'hA0); ev("R10", 64'h80); ev("R10", 64'h20); ev("R10", '0);
    // R8 event selector 0
    wr("R8", 10, 0); wr("R8", 11, 3); wr("R8", 1, 32'h4);
    ev("R8", '1); ev("R8", '0); ev("R8", 64'h1); ev("R8", '0);
    // R9 out of range selectors
    wr("R9", 12, 200); wr("R9", 13, 4); wr("R9", 14, 9); wr("R9", 15, 100);
    wr("R9", 16, 64); wr("R9", 17, 6); wr("R9", 1, 32'h1C);
    ev("R9", '1); ev("R9", 64'h200); ev("R9", '0);
    // R11 bank-1 mask, read-only status, unmapped
    wr("R11", 4, 32'hFFFF_FFFF); rd("R11", 3);
    wr("R11", 0, 0); wr("R11", 3, 0); rd("R11", 0); rd("R11", 3);
    rd("R11", 200); rd("R11", 106); wr("R11", 150, 32'hFF); rd("R11", 150);
    // R4 clear words
    wr("R4", 2, 32'h1); wr("R4", 5, 32'h2); wr("R4", 2, 0);
    rd("R4", 1); rd("R4", 2); rd("R4", 4); rd("R4", 5); rd("R4", 0); rd("R4", 3);
    ev("R4", 64'hA0); ev("R4", '1); ev("R4", '0);
    wr("R4", 5, 32'hFFFF_FFFF); rd("R4", 3);
    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      int a;
      logic [31:0] d;
      a = ($urandom % 3 == 0) ? int'($urandom % 8) : 6 + int'($urandom % 100);
      d = $urandom;
      if (a >= 6) d = (($urandom % 4) == 0) ? 32'(d[7:0]) : 32'($urandom % 64);
      step("R10", {$urandom, $urandom} & {$urandom, $urandom}, ($urandom % 2) == 1, a, d);
    end
    ev("R6", '0); ev("R6", '0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule